// File: doc/BRIEF.md
# Two-Channel Triggered DAC Register Block

This block holds the registers that feed a pair of 12-bit digital-to-analog converter channels. Software reaches it through a single-cycle memory-mapped port with a byte address, a write strobe, write data and combinational read data. Each channel has a holding register that software writes with a new code. It also has an output register that drives the converter. The block moves the code from the first register to the second either at once or on a chosen trigger event.

The control word gives each channel an on bit, a trigger-enable bit and a four-bit source field. The channel B fields repeat the channel A fields sixteen bits higher. Source 0 selects a one-shot software trigger bit that hardware clears by itself. Sources 1 to 7 select one of seven timer strobe inputs, and the block detects their rising edges. A channel that is switched off keeps its output code whatever happens at its inputs.

Top module: `dual_dac_regif`

## Requirements
- R1: After reset every register reads 0 at offsets 0x00, 0x04, 0x08, 0x14, 0x2C and 0x30, and both converter codes are 0.
- R2: The control word at offset 0x00 uses bit 0 for channel A on, bit 1 for channel A trigger enable and bits 5:2 for channel A source. Channel B uses bits 16, 17 and 21:18. Every other bit reads 0.
- R3: The holding registers sit at offsets 0x08 (A) and 0x14 (B). Each keeps write bits 11:0 right-aligned, and bits 31:12 read 0.
- R4: A channel that is on with trigger enable clear loads its holding value into its output one clock after the holding write. On the write edge itself the output still shows the previous value.
- R5: A channel that is on with trigger enable set keeps its output unchanged until its selected trigger occurs.
- R6: Writing 1 to bit 0 (A) or bit 1 (B) of offset 0x04 sets that trigger bit. The bit reads back 1 until the next clock edge, and on that edge it clears and a channel with source 0 loads its output.
- R7: Source s in 1..7 selects timer input s-1. The transfer happens on the first clock edge at which that input is high after being low. An input that stays high causes no further transfer.
- R8: A channel responds only to its own selected source. Timer edges on other inputs, a software trigger bit when the source is not 0, the other channel's software bit, and any source value from 8 to 15 all leave its output unchanged.
- R9: A channel whose on bit is clear never changes its output, whether through holding writes, timer edges or software triggers.
- R10: The output registers read at offsets 0x2C (A) and 0x30 (B). Bus writes to them are ignored, and offsets with no register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tmr_pulse | input | 7 | Timer strobe inputs, rising-edge sensitive |
| dac_code_a | output | 12 | Channel A converter code |
| dac_code_b | output | 12 | Channel B converter code |

## Verification
The hardest case to produce from the ports is a timer input that stays high. A transfer on its rising edge must happen once, and the input must then have no effect while a fresh holding value waits. The bench sweeps every source value against every timer line on both channels. When the line matches the source, the bench keeps the line high, writes a new holding code and confirms the output does not move. The same sweep shows that every non-matching line leaves the output alone.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;

    localparam int CODE_W   = 12;
    localparam int NUM_TMR  = 7;
    localparam int SEL_W    = 4;
    localparam int ADDR_W   = 6;
    localparam int BUS_W    = 32;
    localparam int NUM_CH   = 2;
    localparam int CH_SHIFT = 16;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_SWTRG  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_HOLD_A = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_HOLD_B = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_OUT_A  = 6'h2C;
    localparam logic [ADDR_W-1:0] OFF_OUT_B  = 6'h30;

    // Packed so that on = bit 0, trig_en = bit 1, src = bits 5:2.
    typedef struct packed {
        logic [SEL_W-1:0] src;
        logic             trig_en;
        logic             on;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    function automatic logic [ADDR_W-1:0] hold_offset(int ch);
        return (ch == 0) ? OFF_HOLD_A : OFF_HOLD_B;
    endfunction

    function automatic logic [ADDR_W-1:0] out_offset(int ch);
        return (ch == 0) ? OFF_OUT_A : OFF_OUT_B;
    endfunction

    // Event selected by a channel's source field.
    function automatic logic trig_hit(chan_cfg_t c, logic sw,
                                      logic [NUM_TMR-1:0] rise);
        logic hit;
        hit = 1'b0;
        if (c.src == '0) begin
            hit = sw;
        end else begin
            for (int i = 0; i < NUM_TMR; i++) begin
                if (c.src == SEL_W'(i + 1)) hit = rise[i];
            end
        end
        return hit;
    endfunction

endpackage

// File: rtl/dac_rise_detect.sv
module dac_rise_detect #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/dac_chan_slice.sv
module dac_chan_slice
    import dac_regif_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  chan_cfg_t          cfg,
    input  logic               hold_we,
    input  logic [CW-1:0]      hold_wdata,
    input  logic               sw_fire,
    input  logic [NUM_TMR-1:0] tmr_rise,
    output logic [CW-1:0]      hold_q,
    output logic [CW-1:0]      out_q
);
    logic load_out;

    always_comb begin
        load_out = cfg.on && (!cfg.trig_en || trig_hit(cfg, sw_fire, tmr_rise));
    end

    always_ff @(posedge clk) begin
        if (rst)          hold_q <= '0;
        else if (hold_we) hold_q <= hold_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)           out_q <= '0;
        else if (load_out) out_q <= hold_q;
    end
endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
    import dac_regif_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NUM_TMR-1:0] tmr_pulse,
    output logic [CW-1:0]      dac_code_a,
    output logic [CW-1:0]      dac_code_b
);
    chan_cfg_t          cfg_q  [NUM_CH];
    logic [NUM_CH-1:0]  sw_q;
    logic [NUM_TMR-1:0] tmr_rise;
    logic [CW-1:0]      hold_q [NUM_CH];
    logic [CW-1:0]      out_q  [NUM_CH];

    logic wr_ctrl, wr_sw;
    assign wr_ctrl = bus_we && (bus_addr == OFF_CTRL);
    assign wr_sw   = bus_we && (bus_addr == OFF_SWTRG);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) cfg_q[c] <= '0;
        end else if (wr_ctrl) begin
            for (int c = 0; c < NUM_CH; c++)
                cfg_q[c] <= chan_cfg_t'(bus_wdata[c*CH_SHIFT +: CFG_W]);
        end
    end

    // One-shot bits: live for exactly one cycle unless rewritten.
    always_ff @(posedge clk) begin
        if (rst)        sw_q <= '0;
        else if (wr_sw) sw_q <= bus_wdata[NUM_CH-1:0];
        else            sw_q <= '0;
    end

    dac_rise_detect #(.W(NUM_TMR)) u_rise (
        .clk  (clk),
        .rst  (rst),
        .lvl  (tmr_pulse),
        .rise (tmr_rise)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hold_we;
        assign hold_we = bus_we && (bus_addr == hold_offset(c));

        dac_chan_slice #(.CW(CW)) u_slice (
            .clk        (clk),
            .rst        (rst),
            .cfg        (cfg_q[c]),
            .hold_we    (hold_we),
            .hold_wdata (bus_wdata[CW-1:0]),
            .sw_fire    (sw_q[c]),
            .tmr_rise   (tmr_rise),
            .hold_q     (hold_q[c]),
            .out_q      (out_q[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL: begin
                for (int c = 0; c < NUM_CH; c++)
                    bus_rdata[c*CH_SHIFT +: CFG_W] = cfg_q[c];
            end
            OFF_SWTRG:  bus_rdata[NUM_CH-1:0] = sw_q;
            OFF_HOLD_A: bus_rdata[CW-1:0]     = hold_q[0];
            OFF_HOLD_B: bus_rdata[CW-1:0]     = hold_q[1];
            OFF_OUT_A:  bus_rdata[CW-1:0]     = out_q[0];
            OFF_OUT_B:  bus_rdata[CW-1:0]     = out_q[1];
            default:    bus_rdata = '0;
        endcase
    end

    assign dac_code_a = out_q[0];
    assign dac_code_b = out_q[1];
endmodule

// File: rtl/dual_dac_regif_chk.sv
module dual_dac_regif_chk
    import dac_regif_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_W-1:0]  bus_rdata,
    input chan_cfg_t         cfg_a,
    input chan_cfg_t         cfg_b,
    input logic [NUM_CH-1:0] sw_q,
    input logic [CW-1:0]     hold_a,
    input logic [CW-1:0]     dac_code_a,
    input logic [CW-1:0]     dac_code_b
);
    // R9
    off_a_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_a.on |=> $stable(dac_code_a));

    // R9
    off_b_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_b.on |=> $stable(dac_code_b));

    // R4
    follow_a_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_a.on && !cfg_a.trig_en) |=> (dac_code_a == $past(hold_a)));

    // R5
    wait_sw_a_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_a.on && cfg_a.trig_en && cfg_a.src == '0 && !sw_q[0])
        |=> $stable(dac_code_a));

    // R6
    sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((sw_q != '0) && !(bus_we && bus_addr == OFF_SWTRG)) |=> (sw_q == '0));

    // R10
    sw_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_SWTRG) |-> (bus_rdata[BUS_W-1:NUM_CH] == '0));

    // R3
    hold_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_HOLD_A || bus_addr == OFF_HOLD_B)
        |-> (bus_rdata[BUS_W-1:CW] == '0));
endmodule

bind dual_dac_regif dual_dac_regif_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_rdata  (bus_rdata),
    .cfg_a      (cfg_q[0]),
    .cfg_b      (cfg_q[1]),
    .sw_q       (sw_q),
    .hold_a     (hold_q[0]),
    .dac_code_a (dac_code_a),
    .dac_code_b (dac_code_b)
);

// File: tb/dual_dac_regif_tb.sv
module dual_dac_regif_tb;
    localparam logic [5:0] A_CTRL = 6'h00, A_SW = 6'h04, A_HA = 6'h08,
                           A_HB = 6'h14, A_OA = 6'h2C, A_OB = 6'h30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  tmr_pulse = '0;
    logic [11:0] dac_code_a, dac_code_b;

    int errors = 0;
    int checks = 0;
    logic [11:0] exp_out [2];
    logic [11:0] exp_hold [2];
    logic [31:0] rv;

    always #5 clk = ~clk;

    dual_dac_regif u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_pulse(tmr_pulse),
        .dac_code_a(dac_code_a), .dac_code_b(dac_code_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cw(int ch, int on, int ten, int src);
        return ((32'(src) << 2) | (32'(ten) << 1) | 32'(on)) << (16 * ch);
    endfunction

    function automatic logic [5:0] hoff(int ch);
        return (ch == 0) ? A_HA : A_HB;
    endfunction

    function automatic logic [11:0] code(int ch);
        return (ch == 0) ? dac_code_a : dac_code_b;
    endfunction

    task automatic check_outs(input string tag);
        check({tag, " chA"}, 32'(dac_code_a), 32'(exp_out[0]));
        check({tag, " chB"}, 32'(dac_code_b), 32'(exp_out[1]));
    endtask

    task automatic wr_hold(input int ch, input logic [11:0] v);
        wr(hoff(ch), 32'(v));
        exp_hold[ch] = v;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        exp_out[0] = '0; exp_out[1] = '0;
        exp_hold[0] = '0; exp_hold[1] = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        rd(A_CTRL, rv); check("R1 ctrl", rv, 0);
        rd(A_SW, rv);   check("R1 sw", rv, 0);
        rd(A_HA, rv);   check("R1 holdA", rv, 0);
        rd(A_HB, rv);   check("R1 holdB", rv, 0);
        rd(A_OA, rv);   check("R1 outA", rv, 0);
        rd(A_OB, rv);   check("R1 outB", rv, 0);
        check_outs("R1 codes");

        // R2 control layout, source 15 never fires
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, rv); check("R2 ctrl mask", rv, 32'h003F_003F);
        wr(A_CTRL, cw(0, 1, 0, 5) | cw(1, 0, 1, 9));
        rd(A_CTRL, rv); check("R2 ctrl fields", rv, 32'h0026_0015);
        wr(A_CTRL, 0);

        // R3 holding registers (channels off: R9)
        wr_hold(0, 12'hABC);
        wr(A_HA, 32'hFFFF_FABC);
        rd(A_HA, rv); check("R3 holdA", rv, 32'h0000_0ABC);
        wr(A_HB, 32'h1234_5DEF); exp_hold[1] = 12'hDEF;
        rd(A_HB, rv); check("R3 holdB", rv, 32'h0000_0DEF);
        tick();
        check_outs("R9 off after hold writes");

        // R4 direct mode
        wr(A_CTRL, cw(0, 1, 0, 0) | cw(1, 1, 0, 0));
        tick();
        exp_out[0] = exp_hold[0]; exp_out[1] = exp_hold[1];
        check_outs("R4 enter direct");
        for (int i = 0; i < 16; i++) begin
            automatic int ch = i % 2;
            automatic logic [11:0] v = 12'((i * 273 + 5) & 12'hFFF);
            wr_hold(ch, v);
            check("R4 old value on write edge", 32'(code(ch)), 32'(exp_out[ch]));
            tick();
            exp_out[ch] = v;
            check("R4 new value next clock", 32'(code(ch)), 32'(v));
        end

        // R9 disabled: nothing moves
        wr(A_CTRL, 0);
        wr_hold(0, 12'h111); wr_hold(1, 12'h222);
        @(negedge clk) tmr_pulse = 7'h7F;
        tick(); tmr_pulse = '0;
        wr(A_SW, 32'h3);
        tick(); tick();
        check_outs("R9 disabled ignores all");

        // R5 R7 R8 timer sweep
        for (int ch = 0; ch < 2; ch++) begin
            for (int sel = 1; sel <= 7; sel++) begin
                for (int p = 0; p < 7; p++) begin
                    automatic logic [11:0] v = exp_out[ch] ^ 12'((sel * 7 + p + 1) & 12'hFFF);
                    automatic bit hit = (p == sel - 1);
                    wr(A_CTRL, cw(ch, 1, 1, sel));
                    wr_hold(ch, v);
                    tick();
                    check("R5 waits for trigger", 32'(code(ch)), 32'(exp_out[ch]));
                    @(negedge clk) tmr_pulse[p] = 1'b1;
                    tick();
                    if (hit) exp_out[ch] = v;
                    check(hit ? "R7 selected edge" : "R8 other line ignored",
                          32'(code(ch)), 32'(exp_out[ch]));
                    if (hit) begin
                        wr_hold(ch, v ^ 12'h5A5);
                        tick();
                        check("R7 level held no retrigger", 32'(code(ch)), 32'(exp_out[ch]));
                    end
                    tmr_pulse = '0;
                    tick();
                    check("R9 other channel off", 32'(code(1 - ch)), 32'(exp_out[1 - ch]));
                end
            end
        end

        // R6 software trigger, R8 cross-effects
        for (int ch = 0; ch < 2; ch++) begin
            automatic logic [11:0] v = 12'h3C0 + 12'(ch);
            wr(A_CTRL, cw(ch, 1, 1, 0));
            wr_hold(ch, v);
            tick();
            check("R5 sw source waits", 32'(code(ch)), 32'(exp_out[ch]));
            wr(A_SW, 32'(1 << ch));
            rd(A_SW, rv);
            check("R6 sw bit reads set", rv, 32'(1 << ch));
            check("R6 no load before next edge", 32'(code(ch)), 32'(exp_out[ch]));
            tick();
            exp_out[ch] = v;
            check("R6 sw load", 32'(code(ch)), 32'(v));
            rd(A_SW, rv);
            check("R6 sw bit self clears", rv, 0);

            wr(A_CTRL, cw(ch, 1, 1, 3));
            wr_hold(ch, v ^ 12'hFFF);
            wr(A_SW, 32'h3);
            tick();
            check("R8 sw ignored for timer source", 32'(code(ch)), 32'(exp_out[ch]));

            for (int s = 8; s < 16; s++) begin
                wr(A_CTRL, cw(ch, 1, 1, s));
                @(negedge clk) tmr_pulse = 7'h7F;
                tick(); tmr_pulse = '0;
                wr(A_SW, 32'h3);
                tick();
                check("R8 source above 7 never fires", 32'(code(ch)), 32'(exp_out[ch]));
            end
        end

        wr(A_CTRL, cw(0, 1, 1, 0) | cw(1, 1, 1, 0));
        wr_hold(0, 12'h0F1); wr_hold(1, 12'h0F2);
        wr(A_SW, 32'h1);
        tick();
        exp_out[0] = 12'h0F1;
        check_outs("R8 sw bit only own channel");
        wr(A_SW, 32'h2);
        tick();
        exp_out[1] = 12'h0F2;
        check_outs("R6 channel B sw bit");

        // R10 read-only outputs and unused offsets
        wr(A_OA, 32'hFFFF_FFFF);
        wr(A_OB, 32'h0000_0123);
        tick();
        rd(A_OA, rv); check("R10 outA read-only", rv, 32'(exp_out[0]));
        rd(A_OB, rv); check("R10 outB read-only", rv, 32'(exp_out[1]));
        check_outs("R10 codes unchanged");
        rd(6'h3C, rv); check("R10 unused 0x3C", rv, 0);
        rd(6'h0C, rv); check("R10 unused 0x0C", rv, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule